// File: doc/BRIEF.md
# Sync-Framed Message Packet Parser

This block sits behind a serial receiver and turns a stream of bytes into message packets. It searches the stream for the two-byte start pattern 0xAA then 0x55 and captures the little-endian header that follows. That header holds the length, command, packet count, packet number and three routing descriptors (origin, target and relay), each a medium code and a node address. The block then passes the payload bytes to a downstream sink, marking the first and last bytes.

Each packet ends with exactly one strobe. A one-cycle accept pulse marks a complete packet. A one-cycle drop pulse marks a packet that was rejected because its length or a medium code was out of range. After either strobe the parser goes back to searching for the start pattern. Input bytes arrive on a valid/ready interface. The parser stalls the input only while a payload byte is waiting for a sink that is not ready.

Top module: `msg_pkt_parser`

## Requirements
- R1: A packet starts only after an accepted 0xAA is followed directly by an accepted 0x55. Any other byte after 0xAA abandons the search. Stray bytes produce no strobe.
- R2: While waiting for 0x55, a further 0xAA keeps the search armed, so 0xAA 0xAA 0x55 starts a packet.
- R3: Header byte positions counted from the first sync byte (index 0) are: 2–3 length, 4–5 command, 6 packet count, 7 packet number, 8/9 origin medium/address, 10/11 target medium/address, 12/13 relay medium/address. Two-byte fields take their low byte first.
- R4: `hdr_valid` rises in the cycle after header byte 13 is accepted. It stays high, with all header outputs unchanged, up to and including the cycle of the accept pulse, and falls in the next cycle.
- R5: A packet whose length is 14 carries no payload. `pkt_ok` pulses for one cycle in the cycle after byte 13 is accepted.
- R6: A packet of length L (15..94) forwards L-14 payload bytes unchanged. `pay_valid` follows `in_valid` in the same cycle. `pay_first` marks the first payload byte and `pay_last` marks the last one.
- R7: A length below 14 or above 94 (including any non-zero high byte) drops the packet. `pkt_drop` pulses for one cycle in the cycle after length byte 3 is accepted. The next byte is treated as part of the search.
- R8: A medium code above 2 at index 8, 10 or 12 drops the packet, with `pkt_drop` pulsing in the cycle after that byte is accepted.
- R9: `in_ready` is low only while a payload byte is pending and `pay_ready` is low. Sync and header bytes are always accepted.
- R10: Under reset all strobes and `hdr_valid` are low and `in_ready` is high. `pkt_ok` and `pkt_drop` are never high together.
- R11: `pkt_ok` pulses in the cycle after the last payload byte is accepted by the sink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Incoming byte |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Parser takes the byte this cycle |
| pay_data | output | 8 | Payload byte to the sink |
| pay_valid | output | 1 | Payload byte present |
| pay_first | output | 1 | First payload byte of the packet |
| pay_last | output | 1 | Last payload byte of the packet |
| pay_ready | input | 1 | Sink takes the payload byte |
| hdr_valid | output | 1 | Header outputs hold a checked header |
| hdr_len | output | 16 | Whole-packet length |
| hdr_cmd | output | 16 | Command code |
| hdr_total | output | 8 | Packets in the message |
| hdr_seq | output | 8 | Number of this packet |
| src_medium | output | 8 | Origin medium code |
| src_addr | output | 8 | Origin node address |
| dst_medium | output | 8 | Target medium code |
| dst_addr | output | 8 | Target node address |
| gw_medium | output | 8 | Relay medium code |
| gw_addr | output | 8 | Relay node address |
| pkt_ok | output | 1 | One-cycle accept strobe |
| pkt_drop | output | 1 | One-cycle reject strobe |

## Verification
The payload path and `in_ready` have no register, so they are due in the same cycle as the input that causes them. `hdr_valid`, `pkt_ok` and `pkt_drop` each pass through one register and are due in the cycle after the edge that accepts the deciding byte. The bench drives inputs on the falling edge and compares every output five nanoseconds later, well before the next rising edge. Its behavioural model updates its byte queue on the rising edge, so its expectations shift by exactly one register stage, the same as the design.

// File: rtl/pkt_parse_pkg.sv
package pkt_parse_pkg;
  localparam int unsigned HDR_BYTES   = 14;
  localparam int unsigned FIELD_BYTES = HDR_BYTES - 2;
  localparam int unsigned HIDX_W      = $clog2(HDR_BYTES);
  localparam logic [7:0]  SYNC_A      = 8'hAA;
  localparam logic [7:0]  SYNC_B      = 8'h55;
  localparam logic [7:0]  MED_MAX     = 8'd2;
  localparam int unsigned IDX_LEN_HI  = 3;
  localparam int unsigned IDX_SRC_MED = 8;
  localparam int unsigned IDX_DST_MED = 10;
  localparam int unsigned IDX_GW_MED  = 12;
  localparam int unsigned IDX_LAST    = HDR_BYTES - 1;

  typedef enum logic [1:0] {ST_HUNT, ST_SYNC, ST_HDR, ST_PAY} pstate_t;

  typedef struct packed {
    logic [7:0]  gw_addr;
    logic [7:0]  gw_med;
    logic [7:0]  dst_addr;
    logic [7:0]  dst_med;
    logic [7:0]  src_addr;
    logic [7:0]  src_med;
    logic [7:0]  seq;
    logic [7:0]  total;
    logic [15:0] cmd;
    logic [15:0] len;
  } hdr_t;
endpackage

// File: rtl/pkt_rst_sync.sv
module pkt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/pkt_hdr_regs.sv
module pkt_hdr_regs
  import pkt_parse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HIDX_W-1:0] idx,
  input  logic [7:0]        din,
  output hdr_t              hdr
);
  logic [FIELD_BYTES*8-1:0] fld_q;

  for (genvar g = 0; g < FIELD_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = wr_en && (idx == HIDX_W'(g + 2));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fld_q[g*8 +: 8] <= 8'h00;
      else if (hit) fld_q[g*8 +: 8] <= din;
    end
  end

  assign hdr = hdr_t'(fld_q);
endmodule

// File: rtl/pkt_pay_ctr.sv
module pkt_pay_ctr #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             first,
  output logic             last
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             first_q, first_d;

  always_comb begin
    rem_d   = rem_q;
    first_d = first_q;
    if (load) begin
      rem_d   = load_val;
      first_d = 1'b1;
    end else if (step) begin
      rem_d   = rem_q - CNT_W'(1);
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      first_q <= 1'b0;
    end else if (load || step) begin
      rem_q   <= rem_d;
      first_q <= first_d;
    end
  end

  assign first = first_q;
  assign last  = (rem_q == CNT_W'(1));
endmodule

// File: rtl/pkt_seq_ctrl.sv
module pkt_seq_ctrl
  import pkt_parse_pkg::*;
#(
  parameter int unsigned MAX_PAY = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [7:0]        din,
  input  logic [15:0]       len_cur,
  input  logic              pay_last,
  output pstate_t           st,
  output logic [HIDX_W-1:0] idx,
  output logic              ok,
  output logic              drop,
  output logic              hv,
  output logic              load
);
  localparam logic [15:0] LEN_MIN = 16'(HDR_BYTES);
  localparam logic [15:0] LEN_MAX = 16'(HDR_BYTES + MAX_PAY);

  pstate_t           st_q, st_d;
  logic [HIDX_W-1:0] idx_q, idx_d;
  logic              ok_q, ok_d, drop_q, drop_d, hv_q, hv_d;
  logic [15:0]       len_full;
  logic              len_bad, med_pos, med_bad;

  assign len_full = {din, len_cur[7:0]};
  assign len_bad  = (len_full < LEN_MIN) || (len_full > LEN_MAX);
  assign med_pos  = (idx_q == HIDX_W'(IDX_SRC_MED)) || (idx_q == HIDX_W'(IDX_DST_MED)) ||
                    (idx_q == HIDX_W'(IDX_GW_MED));
  assign med_bad  = med_pos && (din > MED_MAX);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    ok_d   = 1'b0;
    drop_d = 1'b0;
    hv_d   = ok_q ? 1'b0 : hv_q;
    load   = 1'b0;
    if (beat) begin
      case (st_q)
        ST_HUNT: if (din == SYNC_A) st_d = ST_SYNC;
        ST_SYNC: begin
          if (din == SYNC_B) begin
            st_d  = ST_HDR;
            idx_d = HIDX_W'(2);
          end else if (din != SYNC_A) begin
            st_d = ST_HUNT;
          end
        end
        ST_HDR: begin
          idx_d = idx_q + HIDX_W'(1);
          if (idx_q == HIDX_W'(IDX_LEN_HI) && len_bad) begin
            drop_d = 1'b1;
            st_d   = ST_HUNT;
          end else if (med_bad) begin
            drop_d = 1'b1;
            st_d   = ST_HUNT;
          end else if (idx_q == HIDX_W'(IDX_LAST)) begin
            hv_d = 1'b1;
            if (len_cur == LEN_MIN) begin
              ok_d = 1'b1;
              st_d = ST_HUNT;
            end else begin
              load = 1'b1;
              st_d = ST_PAY;
            end
          end
        end
        ST_PAY: begin
          if (pay_last) begin
            ok_d = 1'b1;
            st_d = ST_HUNT;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      idx_q  <= '0;
      ok_q   <= 1'b0;
      drop_q <= 1'b0;
      hv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      ok_q   <= ok_d;
      drop_q <= drop_d;
      hv_q   <= hv_d;
    end
  end

  assign st   = st_q;
  assign idx  = idx_q;
  assign ok   = ok_q;
  assign drop = drop_q;
  assign hv   = hv_q;
endmodule

// File: rtl/msg_pkt_parser.sv
module msg_pkt_parser
  import pkt_parse_pkg::*;
#(
  parameter int unsigned MAX_PAY = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [7:0]  pay_data,
  output logic        pay_valid,
  output logic        pay_first,
  output logic        pay_last,
  input  logic        pay_ready,
  output logic        hdr_valid,
  output logic [15:0] hdr_len,
  output logic [15:0] hdr_cmd,
  output logic [7:0]  hdr_total,
  output logic [7:0]  hdr_seq,
  output logic [7:0]  src_medium,
  output logic [7:0]  src_addr,
  output logic [7:0]  dst_medium,
  output logic [7:0]  dst_addr,
  output logic [7:0]  gw_medium,
  output logic [7:0]  gw_addr,
  output logic        pkt_ok,
  output logic        pkt_drop
);
  localparam int unsigned CNT_W = $clog2(HDR_BYTES + MAX_PAY + 1);

  logic              rst_n_s;
  pstate_t           st;
  logic [HIDX_W-1:0] idx;
  logic              beat, pay_beat, load, last_w;
  hdr_t              hdr;
  logic [CNT_W-1:0]  pay_len;

  pkt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign in_ready  = !((st == ST_PAY) && !pay_ready);
  assign beat      = in_valid && in_ready;
  assign pay_beat  = beat && (st == ST_PAY);
  assign pay_valid = in_valid && (st == ST_PAY);
  assign pay_data  = in_data;
  assign pay_len   = hdr.len[CNT_W-1:0] - CNT_W'(HDR_BYTES);

  pkt_seq_ctrl #(.MAX_PAY(MAX_PAY)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .beat(beat), .din(in_data),
    .len_cur(hdr.len), .pay_last(last_w), .st(st), .idx(idx),
    .ok(pkt_ok), .drop(pkt_drop), .hv(hdr_valid), .load(load)
  );

  pkt_hdr_regs u_hdr (
    .clk(clk), .rst_n(rst_n_s), .wr_en(beat && (st == ST_HDR)),
    .idx(idx), .din(in_data), .hdr(hdr)
  );

  pkt_pay_ctr #(.CNT_W(CNT_W)) u_pay (
    .clk(clk), .rst_n(rst_n_s), .load(load), .load_val(pay_len),
    .step(pay_beat), .first(pay_first), .last(last_w)
  );

  assign pay_last   = last_w;
  assign hdr_len    = hdr.len;
  assign hdr_cmd    = hdr.cmd;
  assign hdr_total  = hdr.total;
  assign hdr_seq    = hdr.seq;
  assign src_medium = hdr.src_med;
  assign src_addr   = hdr.src_addr;
  assign dst_medium = hdr.dst_med;
  assign dst_addr   = hdr.dst_addr;
  assign gw_medium  = hdr.gw_med;
  assign gw_addr    = hdr.gw_addr;
endmodule

// File: rtl/pkt_parser_chk.sv
module pkt_parser_chk #(
  parameter int unsigned MAX_PAY = 80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        pay_valid,
  input logic        pay_ready,
  input logic        pay_last,
  input logic        hdr_valid,
  input logic [15:0] hdr_len,
  input logic [15:0] hdr_cmd,
  input logic [7:0]  hdr_total,
  input logic [7:0]  hdr_seq,
  input logic [7:0]  src_medium,
  input logic [7:0]  dst_medium,
  input logic [7:0]  gw_medium,
  input logic        pkt_ok,
  input logic        pkt_drop
);
  localparam logic [15:0] LMIN = 16'd14;
  localparam logic [15:0] LMAX = 16'(14 + MAX_PAY);

  p_pay_in_pkt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> hdr_valid);
  p_ready_only_bp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !pay_ready);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_ok && pkt_drop));
  p_hdr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !pkt_ok) |=> (hdr_valid && $stable({hdr_len, hdr_cmd, hdr_total, hdr_seq})));
  p_hv_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |=> !hdr_valid);
  p_len_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (hdr_len >= LMIN && hdr_len <= LMAX));
  p_medium_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (src_medium <= 8'd2 && dst_medium <= 8'd2 && gw_medium <= 8'd2));
  p_last_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && pay_ready && pay_last) |=> pkt_ok);
endmodule

bind msg_pkt_parser pkt_parser_chk #(.MAX_PAY(MAX_PAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .pay_valid(pay_valid),
  .pay_ready(pay_ready), .pay_last(pay_last), .hdr_valid(hdr_valid),
  .hdr_len(hdr_len), .hdr_cmd(hdr_cmd), .hdr_total(hdr_total), .hdr_seq(hdr_seq),
  .src_medium(src_medium), .dst_medium(dst_medium), .gw_medium(gw_medium),
  .pkt_ok(pkt_ok), .pkt_drop(pkt_drop)
);

// File: tb/sim_msg_pkt_parser.sv
`timescale 1ns/1ps
module sim_msg_pkt_parser;
  typedef logic [7:0] bq_t[$];

  logic clk, rst_n, in_valid, in_ready, pay_valid, pay_first, pay_last, pay_ready;
  logic hdr_valid, pkt_ok, pkt_drop;
  logic [7:0] in_data, pay_data, hdr_total, hdr_seq;
  logic [7:0] src_medium, src_addr, dst_medium, dst_addr, gw_medium, gw_addr;
  logic [15:0] hdr_len, hdr_cmd;

  int checks = 0, fails = 0, cyc = 0, bp_mode = 0, n_ok = 0, n_drop = 0;

  msg_pkt_parser u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    pay_ready <= (bp_mode == 0) || (cyc % 3 != 0);
  end

  // behavioural reference: the current candidate packet as a byte queue
  logic [7:0] pk[$];
  int plen = 0;
  bit m_ok = 0, m_drop = 0, m_hv = 0;
  logic [15:0] e_cmd; logic [7:0] e_tot, e_seq, e_sm, e_sa, e_dm, e_da, e_gm, e_ga;
  int e_len;

  always @(posedge clk) begin
    if (!rst_n) begin
      pk.delete(); m_ok = 0; m_drop = 0; m_hv = 0;
    end else begin
      bit rdy; int n; logic [7:0] b;
      m_ok = 0; m_drop = 0;
      rdy = !((pk.size() >= 14) && !pay_ready);
      if (in_valid && rdy) begin
        b = in_data; n = pk.size();
        if (n == 0) begin
          if (b == 8'hAA) pk.push_back(b);
        end else if (n == 1) begin
          if (b == 8'h55) pk.push_back(b);
          else if (b != 8'hAA) pk.delete();
        end else begin
          pk.push_back(b); n = n + 1;
          if (n == 4) begin
            plen = {pk[3], pk[2]};
            if (plen < 14 || plen > 94) begin m_drop = 1; pk.delete(); end
          end else if ((n == 9 || n == 11 || n == 13) && b > 8'd2) begin
            m_drop = 1; pk.delete();
          end else if (n == 14) begin
            e_len = plen; e_cmd = {pk[5], pk[4]}; e_tot = pk[6]; e_seq = pk[7];
            e_sm = pk[8]; e_sa = pk[9]; e_dm = pk[10]; e_da = pk[11]; e_gm = pk[12]; e_ga = pk[13];
            if (plen == 14) begin m_ok = 1; pk.delete(); end
          end else if (n > 14 && n == plen) begin
            m_ok = 1; pk.delete();
          end
        end
      end
      m_hv = (pk.size() >= 14) || m_ok;
    end
  end

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
  endtask

  // compare every cycle, mid-way between the falling and rising edges
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      bit inpay, bad; bad = 0;
      inpay = pk.size() >= 14;
      if (pkt_ok) n_ok++;
      if (pkt_drop) n_drop++;
      if (in_ready !== !(inpay && !pay_ready)) begin bad = 1; fail_line("R9", "in_ready", in_ready, !(inpay && !pay_ready)); end
      if (pay_valid !== (inpay && in_valid)) begin bad = 1; fail_line("R6", "pay_valid", pay_valid, inpay && in_valid); end
      if (inpay && in_valid) begin
        if (pay_data !== in_data) begin bad = 1; fail_line("R6", "pay_data", pay_data, in_data); end
        if (pay_first !== (pk.size() == 14)) begin bad = 1; fail_line("R6", "pay_first", pay_first, pk.size() == 14); end
        if (pay_last !== (pk.size() == plen - 1)) begin bad = 1; fail_line("R6", "pay_last", pay_last, pk.size() == plen - 1); end
      end
      if (pkt_ok !== m_ok) begin bad = 1; fail_line("R5/R11", "pkt_ok", pkt_ok, m_ok); end
      if (pkt_drop !== m_drop) begin bad = 1; fail_line("R7/R8", "pkt_drop", pkt_drop, m_drop); end
      if (hdr_valid !== m_hv) begin bad = 1; fail_line("R4", "hdr_valid", hdr_valid, m_hv); end
      if (m_hv) begin
        if ({hdr_len, hdr_cmd, hdr_total, hdr_seq} !== {16'(e_len), e_cmd, e_tot, e_seq}) begin
          bad = 1; fail_line("R3", "len/cmd/total/seq", {hdr_len, hdr_cmd, hdr_total, hdr_seq}, {16'(e_len), e_cmd, e_tot, e_seq});
        end
        if ({src_medium, src_addr, dst_medium, dst_addr, gw_medium, gw_addr} !== {e_sm, e_sa, e_dm, e_da, e_gm, e_ga}) begin
          bad = 1; fail_line("R3", "routing", {src_medium, src_addr, dst_medium, dst_addr, gw_medium, gw_addr},
                             {e_sm, e_sa, e_dm, e_da, e_gm, e_ga});
        end
      end
      checks++;
      if (bad) fails++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; fail_line(req, what, act, exp); end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    #3;
    while (!in_ready) begin @(negedge clk); #3; end
  endtask

  task automatic send(input bq_t q, input int n);
    for (int i = 0; i < n; i++) put(q[i]);
    @(negedge clk); in_valid = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  function automatic bq_t mk(input int len, input logic [15:0] cmd, input logic [7:0] tot, seq,
                             input logic [7:0] sm, sa, dm, da, gm, ga);
    bq_t q;
    q = {8'hAA, 8'h55, 8'(len), 8'(len >> 8), cmd[7:0], cmd[15:8], tot, seq, sm, sa, dm, da, gm, ga};
    for (int i = 14; i < len && i < 200; i++) q.push_back(8'(i * 37 + 5));
    return q;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bq_t q;
    int o, d;
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    #5;
    // R10: reset state
    chk(!pkt_ok && !pkt_drop && !hdr_valid && in_ready && !pay_valid, "R10", "reset outputs",
        {pkt_ok, pkt_drop, hdr_valid, in_ready, pay_valid}, 5'b00010);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5: header only
    o = n_ok; d = n_drop;
    q = mk(14, 16'h1234, 8'd1, 8'd0, 8'd0, 8'd0, 8'd1, 8'd3, 8'd1, 8'd0);
    send(q, q.size());
    chk(n_ok == o + 1 && n_drop == d, "R5", "header-only strobes", n_ok - o, 1);

    // R6 R9 R11: payload with backpressure
    bp_mode = 1; o = n_ok;
    q = mk(19, 16'hBEEF, 8'd3, 8'd2, 8'd2, 8'd5, 8'd0, 8'd0, 8'd2, 8'd0);
    send(q, q.size());
    chk(n_ok == o + 1, "R11", "payload packet done", n_ok - o, 1);

    // R6: single payload byte
    o = n_ok;
    q = mk(15, 16'h0007, 8'd1, 8'd0, 8'd1, 8'd2, 8'd1, 8'd4, 8'd1, 8'd0);
    send(q, q.size());
    chk(n_ok == o + 1, "R6", "one-byte payload", n_ok - o, 1);

    // R1 R2: junk, broken sync, repeated sync byte
    bp_mode = 0; o = n_ok; d = n_drop;
    q = {8'h11, 8'h55, 8'hAA, 8'h12, 8'h55, 8'hAA, 8'hAA, 8'h55};
    begin
      bq_t t;
      t = mk(14, 16'hA5A5, 8'd9, 8'd8, 8'd2, 8'd7, 8'd0, 8'd0, 8'd0, 8'd0);
      for (int i = 2; i < 14; i++) q.push_back(t[i]);
    end
    send(q, q.size());
    chk(n_ok == o + 1 && n_drop == d, "R1", "junk ignored then one packet", n_ok - o, 1);
    chk(n_drop == d, "R2", "no drop on repeated sync", n_drop - d, 0);

    // R7: lengths out of range
    d = n_drop; o = n_ok;
    q = mk(13, 16'h0, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0); send(q, 4);
    q = mk(95, 16'h0, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0); send(q, 4);
    q = mk(270, 16'h0, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0); send(q, 4);
    chk(n_drop == d + 3 && n_ok == o, "R7", "three bad lengths", n_drop - d, 3);

    // R6: largest payload
    o = n_ok; bp_mode = 1;
    q = mk(94, 16'h4321, 8'd255, 8'd254, 8'd2, 8'd6, 8'd1, 8'd0, 8'd0, 8'd0);
    send(q, q.size());
    chk(n_ok == o + 1, "R6", "80-byte payload", n_ok - o, 1);

    // R8: bad medium codes at each descriptor
    bp_mode = 0; d = n_drop;
    q = mk(14, 16'h1, 8'd1, 8'd0, 8'd3, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0); send(q, 9);
    q = mk(14, 16'h1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd7, 8'd0, 8'd0, 8'd0); send(q, 11);
    q = mk(14, 16'h1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'hAA, 8'd0); send(q, 13);
    chk(n_drop == d + 3, "R8", "bad medium drops", n_drop - d, 3);

    // R10: recovery after drops
    o = n_ok;
    q = mk(16, 16'hCAFE, 8'd2, 8'd1, 8'd1, 8'd1, 8'd2, 8'd2, 8'd0, 8'd0);
    send(q, q.size());
    chk(n_ok == o + 1 && !hdr_valid, "R10", "packet after drops", n_ok - o, 1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule